// File: doc/BRIEF.md
# Windowed Watchdog Timer

This peripheral watches over software by running a down-counter that must be restarted periodically, but not too early. A prescaler turns the system clock into a slow tick, nominally 256 Hz, and each tick lowers the count by one. Software restarts the count by writing a keyed command. If the count runs past zero, or a restart arrives while the count is still above a programmed window threshold, the block records a fault. Depending on the configuration, a fault requests a processor reset, requests a full system reset, or raises an interrupt.

Configuration sits in a mode register that takes exactly one write after reset. This prevents errant code from later disabling the watchdog or widening its window. Two halt inputs can freeze the count while the processor is idle or stopped under a debugger, if the matching mode bits allow it. A status register records which kind of fault occurred, and reading it clears it.

Top module: `winwdt`

## Requirements
- R1: A tick is generated once every TICK_DIV clock cycles. The count drops by one on each tick while counting is enabled, so after a reload to value N the next underflow lands between N*TICK_DIV+1 and (N+1)*TICK_DIV clock edges later.
- R2: Only the first write to the mode register (bus_addr 1) after reset is accepted. Every later mode write is ignored, and the readback is unchanged.
- R3: At reset the mode register reads as 0x3FFF2FFF with the default 12-bit count. For a narrower count, the reload and window fields read as all ones of that width and the flag bits are the same.
- R4: Mode register layout: reload value in bits CNT_W-1:0, window threshold in bits 16+CNT_W-1:16, interrupt enable in bit 12, reset enable in bit 13, processor-only reset in bit 14, counter disable in bit 15, halt-in-debug in bit 28, halt-in-idle in bit 29. All other bits read as zero.
- R5: A restart is a write to the control register (bus_addr 0) with 0xA5 in bits 31:24 and bit 0 set. A write with any other key has no effect.
- R6: A restart while the count is at or below the window threshold reloads the count from the reload field. A restart while the count is above the threshold raises a window fault and does not reload.
- R7: A tick that finds the count at zero raises an underflow fault and reloads the count. The count never exceeds the reload value.
- R8: When reset enable is set, any fault sets rst_cpu_o. It also sets rst_sys_o unless processor-only reset is set. Both outputs stay high until the block is reset.
- R9: The status register (bus_addr 2) has bit 0 for underflow and bit 1 for window fault. Every fault sets its bit, whatever the mode. A status read clears both bits, unless a new fault occurs in the same cycle. irq_o is high exactly while a status bit is set and interrupt enable is set.
- R10: While idle_i is high with halt-in-idle set, or dbg_i is high with halt-in-debug set, the count is frozen. A halt input whose mode bit is clear has no effect.
- R11: While the disable bit is set, the count does not move, restarts are ignored and no fault occurs. Because of R2, a locked mode cannot be changed to re-enable or stop the counter.
- R12: bus_rdata presents the addressed register one cycle after bus_rd is high and is zero in every other cycle. Reading the control register returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_i | input | 1 | Processor idle indication |
| dbg_i | input | 1 | Processor halted by debugger |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 mode, 2 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Fault interrupt |
| rst_cpu_o | output | 1 | Processor reset request, sticky |
| rst_sys_o | output | 1 | System reset request, sticky |

## Verification
The bench builds the block with a 5-bit count and a tick every 3 clocks. This puts a full countdown from reload 31 at about 100 cycles, so every reload value, window threshold and restart spacing in the sweep reaches both underflow and window faults quickly. A cycle-level model in the bench is derived from the requirements and is compared against the outputs and read data on every cycle. Directed cases then cover the reset value, the write-once lock, key rejection, the halts, the disable bit and the two reset flavours.

// File: rtl/winwdt_pkg.sv
package winwdt_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL = 2'd0,
    SEL_MODE = 2'd1,
    SEL_STAT = 2'd2
  } reg_sel_e;

  // mode register flag positions
  localparam int F_FIEN      = 12;
  localparam int F_RSTEN     = 13;
  localparam int F_CPUONLY   = 14;
  localparam int F_DIS       = 15;
  localparam int F_DELTA_LSB = 16;
  localparam int F_DBGH      = 28;
  localparam int F_IDLEH     = 29;

  // control register restart command
  localparam int         KEY_LSB      = 24;
  localparam logic [7:0] CTRL_KEY     = 8'hA5;
  localparam int         CTRL_RESTART = 0;

  // status bits
  localparam int ST_UF  = 0;
  localparam int ST_WIN = 1;
  localparam int ST_W   = 2;

  typedef struct packed {
    logic fien;
    logic rsten;
    logic cpuonly;
    logic dis;
    logic idleh;
    logic dbgh;
  } mode_flags_t;

  localparam mode_flags_t FLAGS_RST = '{fien: 1'b0, rsten: 1'b1, cpuonly: 1'b0,
                                        dis: 1'b0, idleh: 1'b1, dbgh: 1'b1};
endpackage

// File: rtl/winwdt_tick.sv
module winwdt_tick #(
  parameter int DIV = 187500
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_pass
      // every clock is a tick
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pc_q;

      always_ff @(posedge clk) begin
        if (rst)               pc_q <= '0;
        else if (pc_q == LAST) pc_q <= '0;
        else                   pc_q <= pc_q + 1'b1;
      end

      assign tick_o = (pc_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/winwdt_regs.sv
module winwdt_regs
  import winwdt_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic              uf_i,
  input  logic              win_i,
  output logic [CNT_W-1:0]  reload_o,
  output logic [CNT_W-1:0]  delta_o,
  output mode_flags_t       flags_o,
  output logic              locked_o,
  output logic              load_o,
  output logic              restart_o,
  output logic [ST_W-1:0]   stat_o,
  output logic              irq_o,
  output logic [BUS_W-1:0]  rdata_o
);
  reg_sel_e sel;
  logic [CNT_W-1:0] reload_q, delta_q;
  mode_flags_t flags_q;
  logic locked_q;
  logic [ST_W-1:0] stat_q, stat_n;
  logic irq_q, fien_n;
  logic [BUS_W-1:0] rdata_q, mode_word, rd_mux;

  assign sel       = reg_sel_e'(addr_i);
  assign load_o    = wr_i && (sel == SEL_MODE) && !locked_q;
  assign restart_o = wr_i && (sel == SEL_CTRL) &&
                     (wdata_i[KEY_LSB +: 8] == CTRL_KEY) && wdata_i[CTRL_RESTART];

  always_comb begin
    mode_word = '0;
    mode_word[CNT_W-1:0]               = reload_q;
    mode_word[F_DELTA_LSB +: CNT_W]    = delta_q;
    mode_word[F_FIEN]                  = flags_q.fien;
    mode_word[F_RSTEN]                 = flags_q.rsten;
    mode_word[F_CPUONLY]               = flags_q.cpuonly;
    mode_word[F_DIS]                   = flags_q.dis;
    mode_word[F_DBGH]                  = flags_q.dbgh;
    mode_word[F_IDLEH]                 = flags_q.idleh;
  end

  always_comb begin
    case (sel)
      SEL_MODE: rd_mux = mode_word;
      SEL_STAT: rd_mux = {{(BUS_W-ST_W){1'b0}}, stat_q};
      default:  rd_mux = '0;
    endcase
  end

  always_comb begin
    stat_n = stat_q;
    if (rd_i && sel == SEL_STAT) stat_n = '0;
    if (uf_i)  stat_n[ST_UF]  = 1'b1;
    if (win_i) stat_n[ST_WIN] = 1'b1;
    fien_n = load_o ? wdata_i[F_FIEN] : flags_q.fien;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '1;
      delta_q  <= '1;
      flags_q  <= FLAGS_RST;
      locked_q <= 1'b0;
      stat_q   <= '0;
      irq_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (load_o) begin
        reload_q        <= wdata_i[CNT_W-1:0];
        delta_q         <= wdata_i[F_DELTA_LSB +: CNT_W];
        flags_q.fien    <= wdata_i[F_FIEN];
        flags_q.rsten   <= wdata_i[F_RSTEN];
        flags_q.cpuonly <= wdata_i[F_CPUONLY];
        flags_q.dis     <= wdata_i[F_DIS];
        flags_q.idleh   <= wdata_i[F_IDLEH];
        flags_q.dbgh    <= wdata_i[F_DBGH];
        locked_q        <= 1'b1;
      end
      stat_q  <= stat_n;
      irq_q   <= fien_n && (stat_n != '0);
      rdata_q <= rd_i ? rd_mux : '0;
    end
  end

  assign reload_o = reload_q;
  assign delta_o  = delta_q;
  assign flags_o  = flags_q;
  assign locked_o = locked_q;
  assign stat_o   = stat_q;
  assign irq_o    = irq_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/winwdt_count.sv
module winwdt_count
  import winwdt_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             idle_i,
  input  logic             dbg_i,
  input  mode_flags_t      flags_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic [CNT_W-1:0] delta_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             restart_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             uf_o,
  output logic             win_o
);
  logic [CNT_W-1:0] cnt_q;
  logic run, rs_act, in_win, rs_ok, step;

  assign run    = !flags_i.dis && !(flags_i.idleh && idle_i) && !(flags_i.dbgh && dbg_i);
  assign rs_act = restart_i && !flags_i.dis;
  assign in_win = (cnt_q <= delta_i);
  assign rs_ok  = rs_act && in_win;
  assign win_o  = rs_act && !in_win;
  assign step   = tick_i && run;
  assign uf_o   = step && (cnt_q == '0) && !rs_ok && !load_i;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '1;
    else if (load_i)        cnt_q <= load_val_i;
    else if (rs_ok)         cnt_q <= reload_i;
    else if (step) begin
      if (cnt_q == '0)      cnt_q <= reload_i;
      else                  cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/winwdt_fault.sv
module winwdt_fault
  import winwdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        uf_i,
  input  logic        win_i,
  input  mode_flags_t flags_i,
  output logic        rst_cpu_o,
  output logic        rst_sys_o
);
  logic cpu_q, sys_q, fault;

  assign fault = uf_i || win_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_q <= 1'b0;
      sys_q <= 1'b0;
    end else if (fault && flags_i.rsten) begin
      cpu_q <= 1'b1;
      if (!flags_i.cpuonly) sys_q <= 1'b1;
    end
  end

  assign rst_cpu_o = cpu_q;
  assign rst_sys_o = sys_q;
endmodule

// File: rtl/winwdt.sv
module winwdt
  import winwdt_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int TICK_DIV = 187500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idle_i,
  input  logic              dbg_i,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq_o,
  output logic              rst_cpu_o,
  output logic              rst_sys_o
);
  logic             tick_w, load_w, restart_w, locked_w, uf_w, win_w;
  logic [CNT_W-1:0] reload_w, delta_w, cnt_w;
  logic [ST_W-1:0]  stat_w;
  mode_flags_t      flags_w;

  winwdt_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick_o(tick_w)
  );

  winwdt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_i(bus_wr), .rd_i(bus_rd), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .uf_i(uf_w), .win_i(win_w), .reload_o(reload_w),
    .delta_o(delta_w), .flags_o(flags_w), .locked_o(locked_w), .load_o(load_w),
    .restart_o(restart_w), .stat_o(stat_w), .irq_o(irq_o), .rdata_o(bus_rdata)
  );

  winwdt_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .tick_i(tick_w), .idle_i(idle_i), .dbg_i(dbg_i),
    .flags_i(flags_w), .reload_i(reload_w), .delta_i(delta_w), .load_i(load_w),
    .load_val_i(bus_wdata[CNT_W-1:0]), .restart_i(restart_w), .cnt_o(cnt_w),
    .uf_o(uf_w), .win_o(win_w)
  );

  winwdt_fault u_fault (
    .clk(clk), .rst(rst), .uf_i(uf_w), .win_i(win_w), .flags_i(flags_w),
    .rst_cpu_o(rst_cpu_o), .rst_sys_o(rst_sys_o)
  );
endmodule

// File: rtl/winwdt_chk.sv
module winwdt_chk
  import winwdt_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              irq_o,
  input logic              rst_cpu_o,
  input logic              rst_sys_o,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  reload,
  input logic [CNT_W-1:0]  delta,
  input logic              locked,
  input logic              dis,
  input logic              uf,
  input logic              win,
  input logic [ST_W-1:0]   stat
);
  // R8
  cpu_sticky_chk: assert property (@(posedge clk) disable iff (rst) rst_cpu_o |=> rst_cpu_o);
  // R8
  sys_needs_cpu_chk: assert property (@(posedge clk) disable iff (rst) rst_sys_o |-> rst_cpu_o);
  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst) cnt <= reload);
  // R9
  rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == SEL_STAT && !uf && !win) |=> (stat == '0));
  // R9
  irq_src_chk: assert property (@(posedge clk) disable iff (rst) irq_o |-> (stat != '0));
  // R11
  dis_quiet_chk: assert property (@(posedge clk) disable iff (rst) dis |-> (!uf && !win));
  // R2
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    locked |=> ($stable(reload) && $stable(delta)));
endmodule

bind winwdt winwdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_addr(bus_addr), .irq_o(irq_o),
  .rst_cpu_o(rst_cpu_o), .rst_sys_o(rst_sys_o), .cnt(cnt_w), .reload(reload_w),
  .delta(delta_w), .locked(locked_w), .dis(flags_w.dis), .uf(uf_w), .win(win_w),
  .stat(stat_w)
);

// File: tb/tb_winwdt.sv
module tb_winwdt;
  localparam int CW   = 5;
  localparam int DIV  = 3;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0, rst = 1'b1, idle_i = 1'b0, dbg_i = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq_o, rst_cpu_o, rst_sys_o;

  int nvec = 0, nerr = 0, cyc = 0;
  bit cmp_en = 0, done = 0;

  winwdt #(.CNT_W(CW), .TICK_DIV(DIV)) dut (
    .clk(clk), .rst(rst), .idle_i(idle_i), .dbg_i(dbg_i), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .rst_cpu_o(rst_cpu_o), .rst_sys_o(rst_sys_o)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] mk(int rl, int dl, bit fi, bit re, bit co, bit di, bit ih, bit dh);
    return 32'(rl & MAXC) | (32'(dl & MAXC) << 16) | (32'(fi) << 12) | (32'(re) << 13) |
           (32'(co) << 14) | (32'(di) << 15) | (32'(dh) << 28) | (32'(ih) << 29);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // cycle model built from the requirements
  int m_presc, m_cnt, m_reload, m_delta;
  bit m_fien, m_rsten, m_cpu, m_dis, m_idleh, m_dbgh, m_lock, m_irq, m_rcpu, m_rsys;
  logic [1:0]  m_stat;
  logic [31:0] m_rdata;

  always @(posedge clk) begin
    bit tick, run, rs, ld, uf, win;
    logic [31:0] rdv;
    if (rst) begin
      m_presc = 0; m_cnt = MAXC; m_reload = MAXC; m_delta = MAXC;
      m_fien = 0; m_rsten = 1; m_cpu = 0; m_dis = 0; m_idleh = 1; m_dbgh = 1;
      m_lock = 0; m_stat = 0; m_irq = 0; m_rcpu = 0; m_rsys = 0; m_rdata = 0;
    end else begin
      tick = (m_presc == DIV - 1);
      m_presc = tick ? 0 : m_presc + 1;
      run = !m_dis && !(m_idleh && idle_i) && !(m_dbgh && dbg_i);
      case (bus_addr)
        2'd1:    rdv = mk(m_reload, m_delta, m_fien, m_rsten, m_cpu, m_dis, m_idleh, m_dbgh);
        2'd2:    rdv = {30'b0, m_stat};
        default: rdv = 0;
      endcase
      rs = bus_wr && bus_addr == 2'd0 && bus_wdata[31:24] == 8'hA5 && bus_wdata[0] && !m_dis;
      ld = bus_wr && bus_addr == 2'd1 && !m_lock;
      uf = 0; win = 0;
      if (ld) m_cnt = int'(bus_wdata) & MAXC;
      else if (rs && m_cnt <= m_delta) m_cnt = m_reload;
      else begin
        if (rs) win = 1;
        if (tick && run) begin
          if (m_cnt == 0) begin uf = 1; m_cnt = m_reload; end
          else m_cnt--;
        end
      end
      if ((uf || win) && m_rsten) begin
        m_rcpu = 1;
        if (!m_cpu) m_rsys = 1;
      end
      if (bus_rd && bus_addr == 2'd2) m_stat = 0;
      if (uf)  m_stat[0] = 1'b1;
      if (win) m_stat[1] = 1'b1;
      if (ld) begin
        m_reload = int'(bus_wdata) & MAXC; m_delta = int'(bus_wdata >> 16) & MAXC;
        m_fien = bus_wdata[12]; m_rsten = bus_wdata[13]; m_cpu = bus_wdata[14];
        m_dis = bus_wdata[15]; m_dbgh = bus_wdata[28]; m_idleh = bus_wdata[29];
        m_lock = 1;
      end
      m_irq = m_fien && (m_stat != 0);
      m_rdata = bus_rd ? rdv : 0;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R9 irq", 32'(irq_o), 32'(m_irq));
      chk("R8 rst_cpu", 32'(rst_cpu_o), 32'(m_rcpu));
      chk("R8 rst_sys", 32'(rst_sys_o), 32'(m_rsys));
      chk("R12 rdata", bus_rdata, m_rdata);
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nerr++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
      summary();
    end
  end

  task automatic do_reset();
    @(negedge clk); rst = 1; idle_i = 0; dbg_i = 0;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bwr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_addr = 0; bus_wdata = 0;
  endtask

  task automatic brd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; bus_addr = 0; d = bus_rdata;
  endtask

  localparam logic [31:0] RESTART = 32'hA500_0001;

  initial begin
    logic [31:0] v;
    int k;
    int rls [5] = '{1, 4, 9, 17, 31};
    int ws  [5] = '{2, 5, 11, 23, 40};

    repeat (2) @(negedge clk);
    cmp_en = 1;
    do_reset();

    // R3: reset value of the mode register
    brd(2'd1, v);
    chk("R3 mode reset value", v, 32'(MAXC) | (32'(MAXC) << 16) | 32'h3000_2000);

    // R8: untouched reset mode underflows into both resets
    wait_n((MAXC + 2) * DIV + 4);
    chk("R8 cpu reset on underflow", 32'(rst_cpu_o), 1);
    chk("R8 system reset on underflow", 32'(rst_sys_o), 1);

    // R4 + R2: field layout with stray bits, then the write-once lock
    do_reset();
    bwr(2'd1, mk(7, 3, 1, 0, 0, 0, 0, 1) | 32'hC0E0_0FE0);
    brd(2'd1, v);
    chk("R4 mode layout", v, mk(7, 3, 1, 0, 0, 0, 0, 1));
    bwr(2'd1, mk(20, 20, 0, 1, 1, 1, 1, 0));
    brd(2'd1, v);
    chk("R2 second mode write ignored", v, mk(7, 3, 1, 0, 0, 0, 0, 1));

    // R1 + R7: underflow latency after a reload
    do_reset();
    bwr(2'd1, mk(6, 6, 1, 0, 0, 0, 0, 0));
    k = 1;
    while (!irq_o && k < 200) begin @(negedge clk); k++; end
    chk("R1 underflow latency in range", 32'(k >= 6 * DIV + 1 && k <= 7 * DIV), 1);
    brd(2'd2, v);
    chk("R7 underflow status bit", v, 32'h1);
    brd(2'd2, v);
    chk("R9 status cleared by read", v, 32'h0);

    // R5 + R6: key rejection and window violation
    do_reset();
    bwr(2'd1, mk(20, 5, 1, 0, 0, 0, 0, 0));
    bwr(2'd0, 32'hA400_0001);
    brd(2'd2, v);
    chk("R5 wrong key ignored", v, 32'h0);
    bwr(2'd0, RESTART);
    brd(2'd2, v);
    chk("R6 early restart is window fault", v, 32'h2);
    brd(2'd2, v);
    chk("R9 window bit cleared by read", v, 32'h0);
    wait_n(45);
    bwr(2'd0, RESTART);
    brd(2'd2, v);
    chk("R6 restart inside window accepted", v, 32'h0);

    // R10: idle halt freezes, debug input without its bit does not
    do_reset();
    bwr(2'd1, mk(4, 4, 1, 0, 0, 0, 1, 0));
    idle_i = 1;
    wait_n(40);
    brd(2'd2, v);
    chk("R10 idle halt freezes count", v, 32'h0);
    idle_i = 0; dbg_i = 1;
    wait_n(30);
    brd(2'd2, v);
    chk("R10 debug input ignored without its bit", v, 32'h1);
    dbg_i = 0;

    // R11: disabled counter, locked against re-enable
    do_reset();
    bwr(2'd1, mk(2, 0, 1, 1, 0, 1, 0, 0));
    wait_n(40);
    bwr(2'd0, RESTART);
    brd(2'd2, v);
    chk("R11 disabled: no fault", v, 32'h0);
    bwr(2'd1, mk(2, 2, 1, 1, 0, 0, 0, 0));
    wait_n(40);
    brd(2'd2, v);
    chk("R11 cannot re-enable after lock", v, 32'h0);
    chk("R11 no reset request", 32'(rst_cpu_o), 0);

    // R8 + R9: processor-only reset, status set without interrupt enable
    do_reset();
    bwr(2'd1, mk(2, 2, 0, 1, 1, 0, 0, 0));
    wait_n(20);
    chk("R8 cpu-only reset", 32'(rst_cpu_o), 1);
    chk("R8 no system reset", 32'(rst_sys_o), 0);
    chk("R9 no irq when disabled", 32'(irq_o), 0);
    brd(2'd2, v);
    chk("R9 status set regardless of irq enable", v, 32'h1);

    // sweep: reload x window x restart spacing, all compared by the model
    foreach (rls[i]) begin
      for (int ds = 0; ds < 3; ds++) begin
        foreach (ws[j]) begin
          int dl;
          dl = (ds == 0) ? 0 : (ds == 1) ? rls[i] / 2 : rls[i];
          do_reset();
          bwr(2'd1, mk(rls[i], dl, 1, 0, 0, 0, 0, 0));
          for (int r = 0; r < 3; r++) begin
            wait_n(ws[j]);
            bwr(2'd0, (ws[j] == 11) ? 32'hA400_0001 : RESTART);
          end
          brd(2'd2, v);
        end
      end
    end

    wait_n(4);
    summary();
  end
endmodule